// File: doc/BRIEF.md
# Masked Processor Control Register File

This block holds sixteen 32-bit processor control registers. Each register has two fixed masks: one marks the bits that software may write, the other marks the bits that software may not write but that keep their state. A bit set in neither mask is reserved. A write stores the permitted bits of the incoming word and keeps the protected bits of the old value, so reserved bits never leave zero. Reads are combinational. A reserved register, or a reserved bit, reads as zero.

Two static configuration inputs choose between two interrupt schemes and turn the paging fields on or off. With the external interrupt controller absent, a pending register follows 32 level-sensitive interrupt lines. After reset, an identity register captures a core index. The core's execution logic uses the block as its control-register bank.

Top module: `ctrlreg_file`

## Requirements
- R1: A write with wrEn high at a rising edge stores (wrData & writable) | (old & protected) into register wrAddr. The new value is readable after that edge.
- R2: Registers 6, 11, 13, 14 and 15 are always reserved. Registers 8, 9 and 10 are reserved without the MMU, and register 4 is reserved with the external controller. A reserved register reads zero and ignores writes.
- R3: Status is register 0, and its bit 0 (previous interrupt enable) is always writable. Registers 1 (exception status), 2 (break status) and 12 (fault address) are fully writable. Registers 5 (core id) and 7 (exception cause) are fully protected, so writes do not change them.
- R4: With the external controller (eicPresent=1), these status fields are writable: bit 23 (register-set interrupt enable), bits 21:16 (previous register set), bits 9:4 (interrupt level) and bit 3 (handler mode). Bit 22 (non-maskable flag) and bits 15:10 (current register set) are protected.
- R5: Without the external controller, status bit 23 is protected, register 3 (interrupt enable) is fully writable and register 4 (interrupt pending) is fully protected.
- R6: With the MMU (mmuPresent=1), status bits 1 (user mode) and 2 (exception handling) are writable. Register 8 bits 31:2 (page-table base and page number) are writable. Register 9 is fully writable. In register 10, bits 5:0 are protected and bits 23:6 are writable.
- R7: Reset clears every register except status, which resets to 0x0080_0000 (bit 23 set).
- R8: On the first rising edge after reset is released, register 5 loads coreIndex. It then holds that value.
- R9: Without the external controller, bit n of register 4 equals irqLevel[n] as sampled at the previous rising edge. With the external controller, register 4 reads zero.
- R10: rdData reflects rdAddr combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eicPresent | input | 1 | External interrupt controller configured |
| mmuPresent | input | 1 | Paging unit configured |
| coreIndex | input | 32 | Value captured by the core-id register |
| irqLevel | input | 32 | Level interrupt lines |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 4 | Write register index |
| wrData | input | 32 | Write value |
| rdAddr | input | 4 | Read register index |
| rdData | output | 32 | Read value |

## Verification
The assertions assume that eicPresent, mmuPresent and coreIndex change only while reset is held. A stored value is only meaningful under the configuration that was in force when it was written. The bench changes these inputs only during reset, once for each of the four configurations, and then sweeps every address with several data patterns. During the write sweeps it keeps irqLevel at zero, so the pending register's contribution stays known. It varies irqLevel only in dedicated phases.

// File: rtl/ctrlreg_pkg.sv
`timescale 1ns/1ps
package ctrlreg_pkg;
  parameter int unsigned REG_COUNT = 16;
  parameter int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W   = $clog2(REG_COUNT);

  // register indices
  parameter int unsigned IDX_STATUS  = 0;
  parameter int unsigned IDX_EXCSTAT = 1;
  parameter int unsigned IDX_BRKSTAT = 2;
  parameter int unsigned IDX_INTEN   = 3;
  parameter int unsigned IDX_INTPEND = 4;
  parameter int unsigned IDX_COREID  = 5;
  parameter int unsigned IDX_CAUSE   = 7;
  parameter int unsigned IDX_PTADDR  = 8;
  parameter int unsigned IDX_TLBACC  = 9;
  parameter int unsigned IDX_TLBCTL  = 10;
  parameter int unsigned IDX_FAULT   = 12;

  // status fields
  parameter int unsigned ST_PIE_LSB  = 0;
  parameter int unsigned ST_USR_LSB  = 1;
  parameter int unsigned ST_EXH_LSB  = 2;
  parameter int unsigned ST_HND_LSB  = 3;
  parameter int unsigned ST_LVL_LSB  = 4;
  parameter int unsigned ST_LVL_W    = 6;
  parameter int unsigned ST_CRS_LSB  = 10;
  parameter int unsigned ST_CRS_W    = 6;
  parameter int unsigned ST_PRS_LSB  = 16;
  parameter int unsigned ST_PRS_W    = 6;
  parameter int unsigned ST_NMI_LSB  = 22;
  parameter int unsigned ST_RSIE_LSB = 23;

  // page-table address fields
  parameter int unsigned PT_PAGE_LSB = 2;
  parameter int unsigned PT_PAGE_W   = 20;
  parameter int unsigned PT_BASE_LSB = 22;
  parameter int unsigned PT_BASE_W   = 10;

  // translation control fields
  parameter int unsigned TC_DIRTY_LSB = 0;
  parameter int unsigned TC_PERM_LSB  = 1;
  parameter int unsigned TC_PERM_W    = 3;
  parameter int unsigned TC_BAD_LSB   = 4;
  parameter int unsigned TC_DBL_LSB   = 5;
  parameter int unsigned TC_PID_LSB   = 6;
  parameter int unsigned TC_PID_W     = 12;
  parameter int unsigned TC_WE_LSB    = 18;
  parameter int unsigned TC_RD_LSB    = 19;
  parameter int unsigned TC_WAY_LSB   = 20;
  parameter int unsigned TC_WAY_W     = 4;

  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    logic [REG_COUNT-1:0] wrSel;
    word_t                wrData;
    logic                 sampleIrq;
    logic                 loadId;
  } strobe_t;

  function automatic word_t fieldMask(int unsigned lsb, int unsigned width);
    word_t m;
    m = '0;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      if (i >= lsb && i < lsb + width) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic word_t resetValue(int unsigned idx);
    return (idx == IDX_STATUS) ? fieldMask(ST_RSIE_LSB, 1) : '0;
  endfunction
endpackage

// File: rtl/ctrlreg_fieldmap.sv
`timescale 1ns/1ps
module ctrlreg_fieldmap
  import ctrlreg_pkg::*;
(
  input  logic                              eicPresent,
  input  logic                              mmuPresent,
  output logic [REG_COUNT-1:0][DATA_W-1:0]  wrMask,
  output logic [REG_COUNT-1:0][DATA_W-1:0]  roMask
);
  localparam word_t ALL_ONES = '1;

  always_comb begin
    wrMask = '0;
    roMask = '0;

    // fields present in every configuration
    wrMask[IDX_STATUS]  = fieldMask(ST_PIE_LSB, 1);
    wrMask[IDX_EXCSTAT] = ALL_ONES;
    wrMask[IDX_BRKSTAT] = ALL_ONES;
    wrMask[IDX_FAULT]   = ALL_ONES;
    roMask[IDX_COREID]  = ALL_ONES;
    roMask[IDX_CAUSE]   = ALL_ONES;

    if (eicPresent) begin
      wrMask[IDX_STATUS] = wrMask[IDX_STATUS]
                         | fieldMask(ST_RSIE_LSB, 1)
                         | fieldMask(ST_PRS_LSB, ST_PRS_W)
                         | fieldMask(ST_LVL_LSB, ST_LVL_W)
                         | fieldMask(ST_HND_LSB, 1);
      roMask[IDX_STATUS] = fieldMask(ST_NMI_LSB, 1)
                         | fieldMask(ST_CRS_LSB, ST_CRS_W);
    end else begin
      roMask[IDX_STATUS]  = fieldMask(ST_RSIE_LSB, 1);
      wrMask[IDX_INTEN]   = ALL_ONES;
      roMask[IDX_INTPEND] = ALL_ONES;
    end

    if (mmuPresent) begin
      wrMask[IDX_STATUS] = wrMask[IDX_STATUS]
                         | fieldMask(ST_USR_LSB, 1)
                         | fieldMask(ST_EXH_LSB, 1);
      wrMask[IDX_PTADDR] = fieldMask(PT_PAGE_LSB, PT_PAGE_W)
                         | fieldMask(PT_BASE_LSB, PT_BASE_W);
      roMask[IDX_TLBCTL] = fieldMask(TC_DIRTY_LSB, 1)
                         | fieldMask(TC_PERM_LSB, TC_PERM_W)
                         | fieldMask(TC_BAD_LSB, 1)
                         | fieldMask(TC_DBL_LSB, 1);
      wrMask[IDX_TLBCTL] = fieldMask(TC_PID_LSB, TC_PID_W)
                         | fieldMask(TC_WE_LSB, 1)
                         | fieldMask(TC_RD_LSB, 1)
                         | fieldMask(TC_WAY_LSB, TC_WAY_W);
      wrMask[IDX_TLBACC] = ALL_ONES;
    end
  end
endmodule

// File: rtl/ctrlreg_ctrl.sv
`timescale 1ns/1ps
module ctrlreg_ctrl
  import ctrlreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              eicPresent,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  word_t             wrData,
  output strobe_t           strobes
);
  logic idPending;

  always_ff @(posedge clk) begin
    if (!rstN) idPending <= 1'b1;
    else       idPending <= 1'b0;
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_sel
    assign strobes.wrSel[g] = wrEn && (wrAddr == ADDR_W'(g));
  end

  assign strobes.wrData    = wrData;
  assign strobes.sampleIrq = !eicPresent;
  assign strobes.loadId    = idPending;
endmodule

// File: rtl/ctrlreg_datapath.sv
`timescale 1ns/1ps
module ctrlreg_datapath
  import ctrlreg_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          strobes,
  input  logic [REG_COUNT-1:0][DATA_W-1:0] wrMask,
  input  logic [REG_COUNT-1:0][DATA_W-1:0] roMask,
  input  word_t                            irqLevel,
  input  word_t                            coreIndex,
  input  logic [ADDR_W-1:0]                rdAddr,
  output word_t                            rdData
);
  logic [REG_COUNT-1:0][DATA_W-1:0] regQ;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    word_t merged;
    assign merged = (strobes.wrData & wrMask[g]) | (regQ[g] & roMask[g]);

    if (g == IDX_INTPEND) begin : g_pend
      always_ff @(posedge clk) begin
        if (!rstN)                  regQ[g] <= resetValue(g);
        else if (strobes.sampleIrq) regQ[g] <= irqLevel;
        else if (strobes.wrSel[g])  regQ[g] <= merged;
      end
    end else if (g == IDX_COREID) begin : g_id
      always_ff @(posedge clk) begin
        if (!rstN)                 regQ[g] <= resetValue(g);
        else if (strobes.loadId)   regQ[g] <= coreIndex;
        else if (strobes.wrSel[g]) regQ[g] <= merged;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)                 regQ[g] <= resetValue(g);
        else if (strobes.wrSel[g]) regQ[g] <= merged;
      end
    end
  end

  assign rdData = regQ[rdAddr] & (wrMask[rdAddr] | roMask[rdAddr]);
endmodule

// File: rtl/ctrlreg_file.sv
`timescale 1ns/1ps
module ctrlreg_file
  import ctrlreg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        eicPresent,
  input  logic        mmuPresent,
  input  logic [31:0] coreIndex,
  input  logic [31:0] irqLevel,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [3:0]  rdAddr,
  output logic [31:0] rdData
);
  strobe_t strobes;
  logic [REG_COUNT-1:0][DATA_W-1:0] wrMask;
  logic [REG_COUNT-1:0][DATA_W-1:0] roMask;

  ctrlreg_fieldmap u_fieldmap (
    .eicPresent (eicPresent),
    .mmuPresent (mmuPresent),
    .wrMask     (wrMask),
    .roMask     (roMask)
  );

  ctrlreg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .eicPresent (eicPresent),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .strobes    (strobes)
  );

  ctrlreg_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrMask    (wrMask),
    .roMask    (roMask),
    .irqLevel  (irqLevel),
    .coreIndex (coreIndex),
    .rdAddr    (rdAddr),
    .rdData    (rdData)
  );
endmodule

// File: rtl/ctrlreg_file_chk.sv
`timescale 1ns/1ps
module ctrlreg_file_chk
  import ctrlreg_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        eicPresent,
  input logic        mmuPresent,
  input logic [31:0] irqLevel,
  input logic [3:0]  rdAddr,
  input logic [31:0] rdData
);
  logic alwaysReserved;
  logic cfgReserved;
  assign alwaysReserved = (rdAddr == 4'd6) || (rdAddr == 4'd11) || (rdAddr >= 4'd13);
  assign cfgReserved    = (!mmuPresent && rdAddr >= 4'd8 && rdAddr <= 4'd10)
                       || (eicPresent && rdAddr == 4'd4);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (alwaysReserved || cfgReserved) |-> rdData == 32'd0);

  // R9
  pending_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !eicPresent && rdAddr == 4'(IDX_INTPEND)) |-> rdData == $past(irqLevel));

  // R8
  coreid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && rdAddr == 4'(IDX_COREID) && $past(rdAddr) == 4'(IDX_COREID))
      |-> rdData == $past(rdData));

  // R4
  status_protected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eicPresent && rdAddr == 4'(IDX_STATUS))
      |-> (rdData[ST_NMI_LSB] == 1'b0 && rdData[ST_CRS_LSB +: ST_CRS_W] == '0));

  // R5
  rsie_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!eicPresent && rdAddr == 4'(IDX_STATUS)) |-> rdData[ST_RSIE_LSB] == 1'b1);

  // R6
  tlbctl_protected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mmuPresent && rdAddr == 4'(IDX_TLBCTL)) |-> rdData[5:0] == 6'd0);
endmodule

bind ctrlreg_file ctrlreg_file_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .eicPresent (eicPresent),
  .mmuPresent (mmuPresent),
  .irqLevel   (irqLevel),
  .rdAddr     (rdAddr),
  .rdData     (rdData)
);

// File: tb/ctrlreg_file_bench.sv
`timescale 1ns/1ps
module ctrlreg_file_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eicPresent = 1'b0;
  logic        mmuPresent = 1'b0;
  logic [31:0] coreIndex = '0;
  logic [31:0] irqLevel = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [31:0] model [16];

  always #4 clk = ~clk;

  ctrlreg_file u_ctrlreg_file (
    .clk(clk), .rstN(rstN), .eicPresent(eicPresent), .mmuPresent(mmuPresent),
    .coreIndex(coreIndex), .irqLevel(irqLevel), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  // writable bits, from R3..R6
  function automatic logic [31:0] expWm(int a, bit e, bit m);
    case (a)
      0:         return 32'h1 | (e ? 32'h00BF_03F8 : 32'h0) | (m ? 32'h6 : 32'h0);
      1, 2, 12:  return 32'hFFFF_FFFF;
      3:         return e ? 32'h0 : 32'hFFFF_FFFF;
      8:         return m ? 32'hFFFF_FFFC : 32'h0;
      9:         return m ? 32'hFFFF_FFFF : 32'h0;
      10:        return m ? 32'h00FF_FFC0 : 32'h0;
      default:   return 32'h0;
    endcase
  endfunction

  // protected bits, from R3..R6
  function automatic logic [31:0] expRm(int a, bit e, bit m);
    case (a)
      0:       return e ? 32'h0040_FC00 : 32'h0080_0000;
      4:       return e ? 32'h0 : 32'hFFFF_FFFF;
      5, 7:    return 32'hFFFF_FFFF;
      10:      return m ? 32'h0000_003F : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(int a, bit e, bit m);
    if ((expWm(a, e, m) | expRm(a, e, m)) == 32'h0) return "R2";
    case (a)
      0:       return e ? "R1 R3 R4 R6" : "R1 R3 R5 R6";
      3, 4:    return "R1 R5";
      5, 7:    return "R3";
      8, 9, 10: return "R1 R6";
      default: return "R1 R3";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic readCheck(int a, logic [31:0] exp, string req);
    rdAddr = 4'(a);
    #1;
    check(req, rdData, exp);
  endtask

  task automatic doWrite(int a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic applyReset(bit e, bit m, logic [31:0] id);
    @(negedge clk);
    rstN = 1'b0; eicPresent = e; mmuPresent = m; coreIndex = id; irqLevel = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 16; a++) model[a] = '0;
    model[0] = 32'h0080_0000;
    model[5] = id;
  endtask

  initial begin
    logic [31:0] pats [4];
    logic [31:0] irqPats [3];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
    pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h5A5A_A5A5;
    irqPats[0] = 32'h8000_0001; irqPats[1] = 32'hFFFF_FFFF; irqPats[2] = 32'h0;

    for (int cfg = 0; cfg < 4; cfg++) begin
      bit e, m;
      e = cfg[0]; m = cfg[1];
      applyReset(e, m, 32'hC0DE_0100 + 32'(cfg));

      // R7 reset values, R8 core id captured
      for (int a = 0; a < 16; a++)
        readCheck(a, model[a] & (expWm(a, e, m) | expRm(a, e, m)),
                  (a == 5) ? "R8" : "R7");

      // R1..R6 write sweep
      for (int a = 0; a < 16; a++) begin
        for (int p = 0; p < 4; p++) begin
          doWrite(a, pats[p]);
          model[a] = (pats[p] & expWm(a, e, m)) | (model[a] & expRm(a, e, m));
          readCheck(a, model[a] & (expWm(a, e, m) | expRm(a, e, m)), reqOf(a, e, m));
        end
      end

      // R8 core id holds after the sweep
      readCheck(5, 32'hC0DE_0100 + 32'(cfg), "R8");

      // R9 pending follows lines, or reads zero with the external controller
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        irqLevel = irqPats[k];
        @(negedge clk);
        readCheck(4, e ? 32'h0 : irqPats[k], "R9");
      end

      // R10 combinational read: switch address without a clock edge
      @(negedge clk);
      readCheck(1, model[1], "R10");
      readCheck(12, model[12], "R10");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule